// File: doc/BRIEF.md
# Next-PC Unit

This block owns the program counter of a single-cycle core and chooses the next fetch address on every rising clock edge. The counter stores a 30-bit word address. The byte address sent to instruction fetch is that word address with two zero bits appended, so an increment is a plain +1 on the word value.

Each cycle the block picks one of three next values:

- the sequential word address;
- a relative branch target, built from the incremented address plus a sign-extended 16-bit offset;
- an absolute jump target, which keeps the top four bits of the current word address and takes its low 26 bits from the jump field.

The decoded branch and jump controls and the ALU zero flag arrive as inputs. The block raises `taken` whenever it redirects the flow. An enable input low freezes the counter, which lets the surrounding core stall. A synchronous reset returns the counter to zero.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the word PC becomes 0, so `fetch_addr` reads 0x00000000 after that edge.
- R2: `fetch_addr[1:0]` is always 0, and `fetch_addr[31:2]` equals the stored word PC.
- R3: With `en` high and `taken` low, the word PC advances by 1 at each edge (`fetch_addr` +4) and wraps from 2^30-1 to 0.
- R4: With `br_eq` high and `zero` high, the next word PC is (PC+1) + sign-extended `br_off`.
- R5: With `br_ne` high and `zero` low, the next word PC is (PC+1) + sign-extended `br_off`.
- R6: A conditional branch whose condition fails (`br_eq` with `zero` low, or `br_ne` with `zero` high) advances the PC by 1 and leaves `taken` low.
- R7: With `jmp` high, the next word PC is {PC[29:26], `jmp_tgt`}, so `fetch_addr` = {PC[29:26], `jmp_tgt`, 2'b00}.
- R8: When `jmp` is high together with `br_eq` or `br_ne`, the jump target is used, whatever the value of `zero`.
- R9: With `en` low, the PC keeps its value at the edge, while `taken` still reflects the controls.
- R10: `taken` is combinational and equals `jmp` | (`br_eq` & `zero`) | (`br_ne` & ~`zero`); it is low when no control is high.
- R11: Bit 15 of `br_off` is the sign bit: a negative offset moves the PC backwards, with modulo 2^30 wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update enable; low holds the PC |
| br_off | input | 16 | Signed word offset for branches |
| jmp_tgt | input | 26 | Low word-address bits of a jump target |
| br_eq | input | 1 | Branch if zero flag set |
| br_ne | input | 1 | Branch if zero flag clear |
| jmp | input | 1 | Unconditional jump |
| zero | input | 1 | ALU equality flag |
| fetch_addr | output | 32 | Byte address for instruction fetch |
| taken | output | 1 | Flow redirect this cycle |

## Verification
The bench walks the counter through runs of plain increments, equal and not-equal branches with each value of the zero flag, and jumps.

- The paired taken and not-taken branches separate the condition logic from the target arithmetic.
- A negative offset from a small PC wraps the counter to the top of the address space. A jump made from there shows that the upper four bits come from the current PC and not from the field.
- A jump issued together with a satisfied branch exposes the selection priority.
- Stalled cycles with live controls show that `taken` keeps following the controls while the address stays frozen.

// File: rtl/nextpc_unit.sv
module nextpc_unit #(
  parameter int WORD_W = 30,
  parameter int OFF_W  = 16,
  parameter int JMP_W  = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [JMP_W-1:0]  jmp_tgt,
  input  logic              br_eq,
  input  logic              br_ne,
  input  logic              jmp,
  input  logic              zero,
  output logic [WORD_W+1:0] fetch_addr,
  output logic              taken
);
  localparam int HI_W = WORD_W - JMP_W;

  logic [WORD_W-1:0] pc_q, pc_inc, br_dst, jmp_dst, pc_d;
  logic              br_hit;

  assign pc_inc  = pc_q + 1'b1;
  assign br_dst  = pc_inc + {{(WORD_W-OFF_W){br_off[OFF_W-1]}}, br_off};
  assign jmp_dst = {pc_q[WORD_W-1 -: HI_W], jmp_tgt};
  assign br_hit  = (br_eq & zero) | (br_ne & ~zero);
  assign taken   = jmp | br_hit;

  always_comb begin
    if (jmp)         pc_d = jmp_dst;
    else if (br_hit) pc_d = br_dst;
    else             pc_d = pc_inc;
  end

  always_ff @(posedge clk) begin
    if (rst)     pc_q <= '0;
    else if (en) pc_q <= pc_d;
  end

  assign fetch_addr = {pc_q, 2'b00};
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic [15:0] br_off,
  input logic [25:0] jmp_tgt,
  input logic        br_eq,
  input logic        br_ne,
  input logic        jmp,
  input logic        zero,
  input logic [31:0] fetch_addr,
  input logic        taken
);
  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> fetch_addr == 32'h0); // R1
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst) fetch_addr[1:0] == 2'b00); // R2
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst) (en && !taken) |=> fetch_addr == $past(fetch_addr) + 32'd4); // R3
  AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst) (br_eq && zero) |-> taken); // R4
  AST_BNE_TAKEN: assert property (@(posedge clk) disable iff (rst) (br_ne && !zero) |-> taken); // R5
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst) (en && jmp) |=> fetch_addr == {$past(fetch_addr[31:28]), $past(jmp_tgt), 2'b00}); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(fetch_addr)); // R9
  AST_IDLE_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst) (!jmp && !br_eq && !br_ne) |-> !taken); // R10
endmodule

bind nextpc_unit nextpc_unit_chk u_chk (.*);

// File: tb/nextpc_unit_bench.sv
module nextpc_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] br_off = '0;
  logic [25:0] jmp_tgt = '0;
  logic        br_eq = 1'b0, br_ne = 1'b0, jmp = 1'b0, zero = 1'b0;
  logic [31:0] fetch_addr;
  logic        taken;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [29:0] model_pc = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  nextpc_unit u_nextpc_unit (
    .clk(clk), .rst(rst), .en(en), .br_off(br_off), .jmp_tgt(jmp_tgt),
    .br_eq(br_eq), .br_ne(br_ne), .jmp(jmp), .zero(zero),
    .fetch_addr(fetch_addr), .taken(taken)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic e, input logic b, input logic n,
                      input logic j, input logic z, input logic [15:0] im,
                      input logic [25:0] jf, input string tag);
    logic t;
    @(negedge clk);
    rst = r; en = e; br_eq = b; br_ne = n; jmp = j; zero = z; br_off = im; jmp_tgt = jf;
    #1;
    t = j | (b & z) | (n & ~z);
    chk("R10 taken", {31'd0, taken}, {31'd0, t});
    if (r)      model_pc = '0;
    else if (!e) model_pc = model_pc;
    else if (j) model_pc = {model_pc[29:26], jf};
    else if (t) model_pc = model_pc + 30'd1 + {{14{im[15]}}, im};
    else        model_pc = model_pc + 30'd1;
    exp_q.push_back({model_pc, 2'b00});
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        chk(tag_q.pop_front(), fetch_addr, exp_q.pop_front());
        chk("R2 align", {30'd0, fetch_addr[1:0]}, 32'd0);
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset", fetch_addr, 32'h0);
    step(0, 1, 0, 0, 0, 0, 16'h0, 26'h0, "R3 seq");
    step(0, 1, 0, 0, 0, 1, 16'h7, 26'h0, "R3 seq zero ignored");
    step(0, 1, 0, 0, 0, 0, 16'h0, 26'h0, "R3 seq");
    step(0, 1, 1, 0, 0, 1, 16'h5, 26'h0, "R4 beq taken");
    step(0, 1, 1, 0, 0, 0, 16'h5, 26'h0, "R6 beq not taken");
    step(0, 1, 0, 1, 0, 0, 16'hFFFD, 26'h0, "R5 bne taken back R11");
    step(0, 1, 0, 1, 0, 1, 16'h9, 26'h0, "R6 bne not taken");
    step(0, 0, 0, 0, 1, 0, 16'h0, 26'h3FFFFFF, "R9 stall with jump");
    step(0, 0, 1, 0, 0, 1, 16'h40, 26'h0, "R9 stall with branch");
    step(0, 1, 0, 0, 1, 0, 16'h0, 26'h123456, "R7 jump");
    step(0, 1, 1, 0, 1, 1, 16'h20, 26'h000100, "R8 jump over beq");
    step(0, 1, 0, 1, 1, 0, 16'h20, 26'h000002, "R8 jump over bne");
    step(0, 1, 0, 1, 0, 0, 16'hFFF8, 26'h0, "R11 negative wrap");
    step(0, 1, 0, 0, 1, 0, 16'h0, 26'h0000010, "R7 upper bits kept");
    step(0, 1, 0, 0, 1, 0, 16'h0, 26'h3FFFFFF, "R7 jump to top");
    step(0, 1, 0, 0, 0, 0, 16'h0, 26'h0, "R3 wrap to zero");
    step(0, 1, 0, 0, 0, 0, 16'h0, 26'h0, "R3 seq after wrap");
    step(0, 1, 1, 0, 0, 1, 16'h7FFF, 26'h0, "R4 max offset");
    step(1, 1, 0, 0, 1, 0, 16'h0, 26'h2AAAAAA, "R1 reset over jump");
    step(0, 1, 0, 0, 0, 0, 16'h0, 26'h0, "R3 seq after reset");
    @(posedge clk);
    #3;
    chk("R10 idle not taken", {31'd0, taken}, 32'd0);
    finish_up();
  end
endmodule